// File: doc/BRIEF.md
# Idle-Driven Voltage and Frequency Governor

This block sets the operating point of a processor core from how busy the core has recently been. It counts the reference-clock cycles in which the core is awake over a fixed window. At the end of each window it turns that busy fraction into the lowest operating point whose speed still covers the demand. Frequency and supply voltage are scaled together. The core is never switched between run and sleep to save power.

Operating points are numbered 0 to LEVELS-1. Level k runs the clock at (k+1)/LEVELS of the maximum. With eight levels and a 700 MHz maximum, the steps are 87.5 MHz apart, and a 60% demand lands on level 4 (437.5 MHz). The voltage code uses the same index, so voltage code k is the lowest supply that safely supports frequency code k.

The block drives two handshakes, one to an external clock synthesizer and one to a supply regulator. Each new code is paired with a request that stays high until the matching circuit reports that it has settled. The governor orders the two steps so that the clock is never faster than the present supply allows. When the enable input is low, the governor parks at the top operating point.

Top module: `dvfs_governor`

## Requirements
- R1: After reset, freq_lvl and volt_lvl both equal LEVELS-1, and freq_req and volt_req are both low.
- R2: While enabled, each window of 2^WIN_LOG2 cycles counts the cycles with core_asleep low (busy count b). The required level is the smallest k with (k+1)/LEVELS >= b/2^WIN_LOG2, or level 0 when b is 0. Code k on freq_lvl or volt_lvl is operating point k.
- R3: At each window end the target moves exactly one level toward the required level, and it stays put when the two are equal.
- R4: On a raise, volt_lvl takes the new code first. freq_lvl moves up only in the cycle after vreg_done is seen, and freq_lvl never exceeds volt_lvl.
- R5: On a lower, freq_lvl takes the new code first. volt_lvl moves down only in the cycle after pll_done is seen.
- R6: Each request stays high until its done input is seen, and the two requests are never high together. A done pulse that arrives while no matching request is pending changes nothing.
- R7: While gov_en is low, the target is LEVELS-1 whatever core_asleep does. When gov_en rises, a fresh window starts in the first enabled cycle.
- R8: Once a sequence completes, freq_lvl and volt_lvl hold the same code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| gov_en | input | 1 | Governor enable; low parks at the top level |
| core_asleep | input | 1 | High in cycles the core spends asleep |
| freq_lvl | output | LW | Frequency operating-point code |
| freq_req | output | 1 | Frequency change pending, held until pll_done |
| pll_done | input | 1 | Clock synthesizer reports the new frequency settled |
| volt_lvl | output | LW | Voltage operating-point code |
| volt_req | output | 1 | Voltage change pending, held until vreg_done |
| vreg_done | input | 1 | Regulator reports the new voltage settled |

## Verification
The bound checker watches the safety side of the design on every cycle:
- the voltage code never falls below the frequency code;
- a frequency rise follows a regulator acknowledgement, and a voltage drop follows a synthesizer acknowledgement;
- requests are exclusive and held until acknowledged;
- the target never jumps more than one level;
- a disabled governor sits at the top level.

Only the bench scenarios can show that the busy count of a whole window maps to the correct level under the ceiling rule, that the target walks one level per window across a sequence of load patterns, and that reset in the middle of a sequence restores the top point. The same holds for a parked governor ignoring stray done pulses.

// File: rtl/dvfs_gov_pkg.sv
`timescale 1ns/1ps
package dvfs_gov_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_VUP,
    SQ_FUP,
    SQ_FDN,
    SQ_VDN
  } seq_state_t;
endpackage

// File: rtl/idle_meter.sv
`timescale 1ns/1ps
// Counts awake cycles over a window of 2^WIN_LOG2 enabled cycles.
module idle_meter #(
  parameter int WIN_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              asleep,
  output logic              win_done,
  output logic [WIN_LOG2:0] busy_total
);
  localparam logic [WIN_LOG2-1:0] LAST = '1;

  logic [WIN_LOG2-1:0] wcnt;
  logic [WIN_LOG2:0]   busy_acc;
  logic [WIN_LOG2:0]   inc;

  assign inc = {{WIN_LOG2{1'b0}}, ~asleep};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wcnt       <= '0;
      busy_acc   <= '0;
      win_done   <= 1'b0;
      busy_total <= '0;
    end else begin
      win_done <= 1'b0;
      wcnt     <= wcnt + 1'b1;
      if (wcnt == LAST) begin
        busy_total <= busy_acc + inc;
        busy_acc   <= '0;
        win_done   <= 1'b1;
      end else begin
        busy_acc <= busy_acc + inc;
      end
    end
  end
endmodule

// File: rtl/level_picker.sv
`timescale 1ns/1ps
// Maps a window busy count to the required level and moves the target one step.
module level_picker #(
  parameter int WIN_LOG2 = 16,
  parameter int LEVELS   = 8,
  localparam int LW      = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              win_done,
  input  logic [WIN_LOG2:0] busy_total,
  output logic [LW-1:0]     tgt
);
  localparam int          PW  = WIN_LOG2 + LW + 2;
  localparam logic [LW-1:0] TOP = LW'(LEVELS - 1);

  logic [PW-1:0] scaled;
  logic [PW-1:0] ceil_q;
  logic [LW-1:0] need_lvl;

  always_comb begin
    scaled = PW'(busy_total) * PW'(LEVELS);
    ceil_q = (scaled + PW'((1 << WIN_LOG2) - 1)) >> WIN_LOG2;
    if (ceil_q == '0)
      need_lvl = '0;
    else if (ceil_q > PW'(LEVELS))
      need_lvl = TOP;
    else
      need_lvl = LW'(ceil_q - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      tgt <= TOP;
    end else if (win_done) begin
      if (need_lvl > tgt)
        tgt <= tgt + 1'b1;
      else if (need_lvl < tgt)
        tgt <= tgt - 1'b1;
    end
  end
endmodule

// File: rtl/vf_sequencer.sv
`timescale 1ns/1ps
// Orders voltage and frequency steps so the clock never outruns the supply.
module vf_sequencer
  import dvfs_gov_pkg::*;
#(
  parameter int LEVELS = 8,
  localparam int LW    = $clog2(LEVELS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] goal,
  output logic [LW-1:0] freq_lvl,
  output logic          freq_req,
  input  logic          pll_done,
  output logic [LW-1:0] volt_lvl,
  output logic          volt_req,
  input  logic          vreg_done
);
  localparam logic [LW-1:0] TOP = LW'(LEVELS - 1);

  seq_state_t    st;
  logic [LW-1:0] goal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      goal_q   <= TOP;
      freq_lvl <= TOP;
      volt_lvl <= TOP;
      freq_req <= 1'b0;
      volt_req <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (goal > freq_lvl) begin
            goal_q   <= goal;
            volt_lvl <= goal;
            volt_req <= 1'b1;
            st       <= SQ_VUP;
          end else if (goal < freq_lvl) begin
            goal_q   <= goal;
            freq_lvl <= goal;
            freq_req <= 1'b1;
            st       <= SQ_FDN;
          end
        end
        SQ_VUP: if (vreg_done) begin
          volt_req <= 1'b0;
          freq_lvl <= goal_q;
          freq_req <= 1'b1;
          st       <= SQ_FUP;
        end
        SQ_FUP: if (pll_done) begin
          freq_req <= 1'b0;
          st       <= SQ_IDLE;
        end
        SQ_FDN: if (pll_done) begin
          freq_req <= 1'b0;
          volt_lvl <= goal_q;
          volt_req <= 1'b1;
          st       <= SQ_VDN;
        end
        SQ_VDN: if (vreg_done) begin
          volt_req <= 1'b0;
          st       <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dvfs_governor.sv
`timescale 1ns/1ps
module dvfs_governor #(
  parameter int WIN_LOG2 = 16,
  parameter int LEVELS   = 8,
  localparam int LW      = $clog2(LEVELS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gov_en,
  input  logic          core_asleep,
  output logic [LW-1:0] freq_lvl,
  output logic          freq_req,
  input  logic          pll_done,
  output logic [LW-1:0] volt_lvl,
  output logic          volt_req,
  input  logic          vreg_done
);
  logic              win_done;
  logic [WIN_LOG2:0] busy_total;
  logic [LW-1:0]     tgt;

  idle_meter #(.WIN_LOG2(WIN_LOG2)) u_meter (
    .clk(clk), .rst(rst), .en(gov_en), .asleep(core_asleep),
    .win_done(win_done), .busy_total(busy_total)
  );

  level_picker #(.WIN_LOG2(WIN_LOG2), .LEVELS(LEVELS)) u_picker (
    .clk(clk), .rst(rst), .en(gov_en), .win_done(win_done),
    .busy_total(busy_total), .tgt(tgt)
  );

  vf_sequencer #(.LEVELS(LEVELS)) u_seq (
    .clk(clk), .rst(rst), .goal(tgt),
    .freq_lvl(freq_lvl), .freq_req(freq_req), .pll_done(pll_done),
    .volt_lvl(volt_lvl), .volt_req(volt_req), .vreg_done(vreg_done)
  );
endmodule

// File: rtl/dvfs_governor_chk.sv
`timescale 1ns/1ps
module dvfs_governor_chk #(
  parameter int LEVELS = 8,
  localparam int LW    = $clog2(LEVELS)
) (
  input logic          clk,
  input logic          rst,
  input logic          gov_en,
  input logic [LW-1:0] tgt,
  input logic [LW-1:0] freq_lvl,
  input logic          freq_req,
  input logic          pll_done,
  input logic [LW-1:0] volt_lvl,
  input logic          volt_req,
  input logic          vreg_done
);
  localparam logic [LW-1:0] TOP = LW'(LEVELS - 1);

  a_r4_volt_covers_freq: assert property (@(posedge clk) disable iff (rst)
    volt_lvl >= freq_lvl);

  a_r4_freq_up_after_vreg: assert property (@(posedge clk) disable iff (rst)
    (freq_lvl > $past(freq_lvl)) |-> $past(vreg_done));

  a_r5_volt_down_after_pll: assert property (@(posedge clk) disable iff (rst)
    (volt_lvl < $past(volt_lvl)) |-> $past(pll_done));

  a_r6_one_req: assert property (@(posedge clk) disable iff (rst)
    !(freq_req && volt_req));

  a_r6_vreq_held: assert property (@(posedge clk) disable iff (rst)
    (volt_req && !vreg_done) |=> volt_req);

  a_r6_freq_req_held: assert property (@(posedge clk) disable iff (rst)
    (freq_req && !pll_done) |=> freq_req);

  a_r3_one_step: assert property (@(posedge clk) disable iff (rst)
    (gov_en && $past(gov_en)) |->
      (tgt == $past(tgt) ||
       {1'b0, tgt} == {1'b0, $past(tgt)} + 1'b1 ||
       {1'b0, tgt} + 1'b1 == {1'b0, $past(tgt)}));

  a_r7_parked_top: assert property (@(posedge clk) disable iff (rst)
    !gov_en |=> tgt == TOP);
endmodule

bind dvfs_governor dvfs_governor_chk #(.LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst(rst), .gov_en(gov_en), .tgt(tgt),
  .freq_lvl(freq_lvl), .freq_req(freq_req), .pll_done(pll_done),
  .volt_lvl(volt_lvl), .volt_req(volt_req), .vreg_done(vreg_done)
);

// File: tb/test_dvfs_governor.sv
`timescale 1ns/1ps
module test_dvfs_governor;
  localparam int WL   = 6;
  localparam int WIN  = 1 << WL;
  localparam int LV   = 8;
  localparam int NV   = 12;
  localparam int VDLY = 3;
  localparam int PDLY = 5;
  // busy cycles per window and expected level after that window (start at 7)
  localparam int VEC_BUSY [NV] = '{64, 38, 38, 38, 38, 0, 1, 8, 9, 64, 64, 17};
  localparam int VEC_LVL  [NV] = '{ 7,  6,  5,  4,  4, 3, 2, 1, 1,  2,  3,  2};

  logic       clk = 0, rst = 1, gov_en = 0, core_asleep = 1;
  logic [2:0] freq_lvl, volt_lvl;
  logic       freq_req, volt_req, pll_done, vreg_done;
  logic       mdl_p = 0, mdl_v = 0, spur_p = 0, spur_v = 0;
  int         pcnt = 0, vcnt = 0;
  int         tests = 0, fails = 0, order_bad = 0;
  int         mid_f, mid_v;

  always #4 clk = ~clk;

  assign pll_done  = mdl_p | spur_p;
  assign vreg_done = mdl_v | spur_v;

  dvfs_governor #(.WIN_LOG2(WL), .LEVELS(LV)) i_dvfs_governor (
    .clk(clk), .rst(rst), .gov_en(gov_en), .core_asleep(core_asleep),
    .freq_lvl(freq_lvl), .freq_req(freq_req), .pll_done(pll_done),
    .volt_lvl(volt_lvl), .volt_req(volt_req), .vreg_done(vreg_done)
  );

  // settle models for the clock synthesizer and the regulator
  always @(negedge clk) begin
    mdl_p <= 1'b0;
    mdl_v <= 1'b0;
    if (freq_req && !mdl_p) begin
      if (pcnt == PDLY) begin mdl_p <= 1'b1; pcnt <= 0; end
      else pcnt <= pcnt + 1;
    end else pcnt <= 0;
    if (volt_req && !mdl_v) begin
      if (vcnt == VDLY) begin mdl_v <= 1'b1; vcnt <= 0; end
      else vcnt <= vcnt + 1;
    end else vcnt <= 0;
  end

  // ordering monitor for R4/R5/R6
  always @(negedge clk) begin
    if (!rst && (freq_lvl > volt_lvl)) order_bad = order_bad + 1;
    if (!rst && freq_req && volt_req)  order_bad = order_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // entered and left at a negedge; samples outputs before cycle 40
  task automatic run_cycles(input int busy, input int n);
    for (int c = 0; c < n; c++) begin
      core_asleep = (c >= busy);
      if (c == 40) begin mid_f = freq_lvl; mid_v = volt_lvl; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(freq_lvl == 3'd7 && volt_lvl == 3'd7, "R1 reset levels", freq_lvl, 7);
    chk(!freq_req && !volt_req, "R1 reset requests", {freq_req, volt_req}, 0);
    rst = 0;
    @(negedge clk);
    gov_en = 1;
    // vector walk: R2 ceiling mapping, R3 single step, R8 equal codes
    for (int i = 0; i < NV; i++) begin
      run_cycles(VEC_BUSY[i], WIN);
      if (i > 0) begin
        chk(mid_f == VEC_LVL[i-1], "R2/R3 freq level", mid_f, VEC_LVL[i-1]);
        chk(mid_v == VEC_LVL[i-1], "R8 volt level", mid_v, VEC_LVL[i-1]);
      end
    end
    run_cycles(WIN, 41);
    chk(mid_f == VEC_LVL[NV-1], "R3 last freq level", mid_f, VEC_LVL[NV-1]);
    chk(mid_v == VEC_LVL[NV-1], "R8 last volt level", mid_v, VEC_LVL[NV-1]);
    // R7: disabled parks at top even when fully asleep
    gov_en = 0;
    run_cycles(0, 30);
    chk(freq_lvl == 3'd7 && volt_lvl == 3'd7, "R7 parked top", freq_lvl, 7);
    run_cycles(0, 200);
    chk(freq_lvl == 3'd7, "R7 still top while asleep", freq_lvl, 7);
    // R6: stray done pulses while idle are ignored
    spur_p = 1; spur_v = 1;
    @(negedge clk);
    spur_p = 0; spur_v = 0;
    run_cycles(0, 3);
    chk(freq_lvl == 3'd7 && volt_lvl == 3'd7 && !freq_req && !volt_req,
        "R6 stray done ignored", freq_lvl, 7);
    // R7 fresh window + R5 frequency lowered first
    gov_en = 1;
    run_cycles(0, WIN);
    run_cycles(0, 4);
    chk(freq_lvl == 3'd6, "R5 freq lowered first", freq_lvl, 6);
    chk(volt_lvl == 3'd7 && freq_req, "R5 volt still high", volt_lvl, 7);
    // R1: reset in the middle of a sequence
    rst = 1;
    repeat (3) @(negedge clk);
    chk(freq_lvl == 3'd7 && volt_lvl == 3'd7, "R1 mid-run reset levels", volt_lvl, 7);
    chk(!freq_req && !volt_req, "R1 mid-run reset requests", {freq_req, volt_req}, 0);
    chk(order_bad == 0, "R4 ordering monitor", order_bad, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule